// File: doc/BRIEF.md
# Parallel ADC Result Reader

This block is a host-side controller for an analog-to-digital converter that returns its results over a parallel bus. It watches the converter's busy line. Once a conversion has finished, it runs one or two read cycles, driving active-low chip-select and read strobes. It then rebuilds the sample and hands it downstream on a ready/valid port. The access delay, the read-low width and the bus turnaround are parameters counted in system clock cycles.

In word mode, one read returns the whole result on a 12-bit bus. In byte mode, the result arrives in two 8-bit halves over bus bits 7:0. A high-byte-enable output selects the half: the low half is read first, then the high half. The high half carries the top four result bits, a 2-bit channel number and two bits that must always be zero. A 10-bit resolution input selects left-justified 10-bit results. These are returned right-justified in a 12-bit sample with zero padding.

Top module: `adc_par_reader`

## Requirements
- R1: While reset is high, and on the first cycle after it, cs_n and rd_n are high, hben is low and samp_valid is low.
- R2: A read sequence starts only after busy has been seen going from 1 to 0. No read strobe goes low while busy is high. A fall of busy that arrives while a read or handoff is pending is remembered.
- R3: Every read keeps rd_n low for exactly max(RD_LOW_CYC, ACCESS_CYC+1) clock cycles. The bus is sampled at the clock edge where rd_n returns high, so data driven only ACCESS_CYC cycles after both strobes went low is captured correctly.
- R4: In word mode (word_mode=1) with 12-bit resolution (ten_bit=0), samp_data equals bus_in[11:0], samp_chan is 0 and samp_err is 0.
- R5: In word mode with 10-bit resolution (ten_bit=1), samp_data is {2'b00, bus_in[11:2]}, and bus_in[1:0] has no effect.
- R6: In byte mode (word_mode=0), there are exactly two read strobes. cs_n stays low from the first strobe to the end of the second, hben is 0 during the first strobe and 1 during the second, and hben does not change while rd_n is low. bus_in[11:8] has no effect.
- R7: In byte mode with 12-bit resolution, samp_data = {H[3:0], L[7:0]} and samp_chan = H[5:4]. Here L is the first byte read and H is the second.
- R8: In byte mode with 10-bit resolution, samp_data = {2'b00, H[3:0], L[7:2]}, and L[1:0] has no effect.
- R9: In byte mode, samp_err is 1 with the sample exactly when H[7:6] is nonzero. In word mode it is 0.
- R10: Between two read strobes, rd_n stays high for at least TURN_CYC cycles. After the last strobe of a sequence, cs_n returns high.
- R11: samp_valid stays high, with samp_data stable, until samp_ready is high. No new read starts while a sample is waiting. With samp_ready held high, samp_valid is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| word_mode | input | 1 | 1: one 12-bit read, 0: two byte reads |
| ten_bit | input | 1 | 1: converter delivers 10-bit results |
| busy | input | 1 | Converter busy, high during conversion |
| bus_in | input | 12 | Converter data bus |
| cs_n | output | 1 | Chip-select, active low |
| rd_n | output | 1 | Read strobe, active low |
| hben | output | 1 | High-byte enable in byte mode |
| samp_ready | input | 1 | Downstream ready |
| samp_valid | output | 1 | Sample valid |
| samp_data | output | 12 | Right-justified sample |
| samp_chan | output | 2 | Channel number (0 in word mode) |
| samp_err | output | 1 | Reserved high-byte bits were nonzero |

## Verification
A sequencer stuck in the wrong state shows up within one read cycle. Either a strobe fails to fall, or it falls during busy. The bench's bus model drives garbage before the access delay and outside the strobes, so a capture on the wrong edge corrupts samp_data on that same sample. A lost low byte or a swapped hben order gives the wrong data or channel on the first byte-mode transfer. A counter off by one shows up as a strobe width or gap count that differs from the expected one in the same transaction.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam int RES_W  = 12;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = RES_W - BYTE_W;
    localparam int CHAN_W = 2;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LOW,
        SQ_GAP,
        SQ_TURN
    } seq_st_e;

    typedef struct packed {
        logic [RES_W-1:0]  data;
        logic [CHAN_W-1:0] chan;
        logic              err;
    } sample_t;

    function automatic sample_t pack_word(input logic [RES_W-1:0] bus,
                                          input logic ten);
        sample_t s;
        s.data = ten ? {2'b00, bus[RES_W-1:2]} : bus;
        s.chan = '0;
        s.err  = 1'b0;
        return s;
    endfunction

    function automatic sample_t pack_bytes(input logic [BYTE_W-1:0] lo,
                                           input logic [BYTE_W-1:0] hi,
                                           input logic ten);
        sample_t s;
        if (ten)
            s.data = {2'b00, hi[NIB_W-1:0], lo[BYTE_W-1:2]};
        else
            s.data = {hi[NIB_W-1:0], lo};
        s.chan = hi[NIB_W+CHAN_W-1:NIB_W];
        s.err  = |hi[BYTE_W-1:NIB_W+CHAN_W];
        return s;
    endfunction

endpackage

// File: rtl/adc_busy_watch.sv
module adc_busy_watch (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic take,
    output logic pend
);
    logic busy_q;
    logic fall;

    assign fall = busy_q & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            busy_q <= busy;
            pend   <= (pend | fall) & ~take;
        end
    end
endmodule

// File: rtl/adc_bus_seq.sv
module adc_bus_seq
    import adc_rd_pkg::*;
#(
    parameter int LOW_CYC  = 3,
    parameter int TURN_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic word_mode,
    input  logic ten_bit,
    output logic take,
    output logic cs_n,
    output logic rd_n,
    output logic hben,
    output logic cap_lo,
    output logic cap_last,
    output logic word_q,
    output logic ten_q
);
    localparam int MAX_C = (LOW_CYC > TURN_CYC) ? LOW_CYC : TURN_CYC;
    localparam int CNT_W = $clog2(MAX_C + 1);
    localparam logic [CNT_W-1:0] LOW_END  = CNT_W'(LOW_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_END = CNT_W'(TURN_CYC - 1);

    seq_st_e          st;
    logic [CNT_W-1:0] cnt;
    logic             cap;

    assign take     = (st == SQ_IDLE) && go;
    assign cap      = (st == SQ_LOW) && (cnt == LOW_END);
    assign cap_lo   = cap && !word_q && !hben;
    assign cap_last = cap && (word_q || hben);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SQ_IDLE;
            cnt    <= '0;
            cs_n   <= 1'b1;
            rd_n   <= 1'b1;
            hben   <= 1'b0;
            word_q <= 1'b0;
            ten_q  <= 1'b0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (take) begin
                        st     <= SQ_LOW;
                        cnt    <= '0;
                        cs_n   <= 1'b0;
                        rd_n   <= 1'b0;
                        hben   <= 1'b0;
                        word_q <= word_mode;
                        ten_q  <= ten_bit;
                    end
                end
                SQ_LOW: begin
                    if (cap) begin
                        rd_n <= 1'b1;
                        cnt  <= '0;
                        if (cap_lo) begin
                            st   <= SQ_GAP;
                            hben <= 1'b1;
                        end else begin
                            st   <= SQ_TURN;
                            cs_n <= 1'b1;
                            hben <= 1'b0;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_GAP: begin
                    if (cnt == TURN_END) begin
                        st   <= SQ_LOW;
                        cnt  <= '0;
                        rd_n <= 1'b0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_TURN: begin
                    if (cnt == TURN_END) begin
                        st  <= SQ_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_sample_pack.sv
module adc_sample_pack
    import adc_rd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [RES_W-1:0] bus,
    input  logic             cap_lo,
    input  logic             cap_last,
    input  logic             word_q,
    input  logic             ten_q,
    input  logic             ready,
    output sample_t          samp,
    output logic             valid
);
    logic [BYTE_W-1:0] lo_q;
    sample_t           next_s;

    always_comb begin
        if (word_q)
            next_s = pack_word(bus, ten_q);
        else
            next_s = pack_bytes(lo_q, bus[BYTE_W-1:0], ten_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q  <= '0;
            samp  <= '0;
            valid <= 1'b0;
        end else begin
            if (cap_lo)
                lo_q <= bus[BYTE_W-1:0];
            if (cap_last) begin
                samp  <= next_s;
                valid <= 1'b1;
            end else if (ready) begin
                valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/adc_par_reader.sv
module adc_par_reader
    import adc_rd_pkg::*;
#(
    parameter int RD_LOW_CYC = 3,
    parameter int ACCESS_CYC = 2,
    parameter int TURN_CYC   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_mode,
    input  logic              ten_bit,
    input  logic              busy,
    input  logic [RES_W-1:0]  bus_in,
    output logic              cs_n,
    output logic              rd_n,
    output logic              hben,
    input  logic              samp_ready,
    output logic              samp_valid,
    output logic [RES_W-1:0]  samp_data,
    output logic [CHAN_W-1:0] samp_chan,
    output logic              samp_err
);
    localparam int LOW_CYC = (RD_LOW_CYC > ACCESS_CYC) ? RD_LOW_CYC : ACCESS_CYC + 1;

    logic    pend, take, go;
    logic    cap_lo, cap_last, word_q, ten_q;
    sample_t samp;

    assign go = pend && !busy && !samp_valid;

    adc_busy_watch u_watch (
        .clk  (clk),
        .rst  (rst),
        .busy (busy),
        .take (take),
        .pend (pend)
    );

    adc_bus_seq #(
        .LOW_CYC  (LOW_CYC),
        .TURN_CYC (TURN_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .word_mode (word_mode),
        .ten_bit   (ten_bit),
        .take      (take),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .hben      (hben),
        .cap_lo    (cap_lo),
        .cap_last  (cap_last),
        .word_q    (word_q),
        .ten_q     (ten_q)
    );

    adc_sample_pack u_pack (
        .clk      (clk),
        .rst      (rst),
        .bus      (bus_in),
        .cap_lo   (cap_lo),
        .cap_last (cap_last),
        .word_q   (word_q),
        .ten_q    (ten_q),
        .ready    (samp_ready),
        .samp     (samp),
        .valid    (samp_valid)
    );

    assign samp_data = samp.data;
    assign samp_chan = samp.chan;
    assign samp_err  = samp.err;
endmodule

// File: rtl/adc_par_reader_chk.sv
module adc_par_reader_chk #(
    parameter int LOW_CYC  = 3,
    parameter int TURN_CYC = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        cs_n,
    input logic        rd_n,
    input logic        hben,
    input logic        samp_ready,
    input logic        samp_valid,
    input logic [11:0] samp_data
);
    int lo_cnt;
    int hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt <= 0;
            hi_cnt <= 0;
        end else begin
            lo_cnt <= rd_n ? 0 : lo_cnt + 1;
            hi_cnt <= !rd_n ? 0 : ((hi_cnt < TURN_CYC) ? hi_cnt + 1 : hi_cnt);
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cs_n && rd_n && !hben && !samp_valid));

    // R6
    rd_in_cs_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !cs_n);

    // R6
    hben_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_n && !$past(rd_n)) |-> $stable(hben));

    // R2
    no_busy_read_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> !$past(busy));

    // R3
    low_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_n) |-> (lo_cnt == LOW_CYC));

    // R10
    turn_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_n) |-> (hi_cnt >= TURN_CYC));

    // R11
    hold_sample_chk: assert property (@(posedge clk) disable iff (rst)
        (samp_valid && !samp_ready) |=> (samp_valid && $stable(samp_data)));

    // R11
    no_read_pending_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> !$past(samp_valid));
endmodule

bind adc_par_reader adc_par_reader_chk #(
    .LOW_CYC  (LOW_CYC),
    .TURN_CYC (TURN_CYC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .hben       (hben),
    .samp_ready (samp_ready),
    .samp_valid (samp_valid),
    .samp_data  (samp_data)
);

// File: tb/adc_par_reader_test.sv
module adc_par_reader_test;
    localparam int ACC  = 3;
    localparam int RDL  = 2;
    localparam int TRN  = 3;
    localparam int LOWC = (RDL > ACC) ? RDL : ACC + 1;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst = 1'b1, word_mode = 1'b1, ten_bit = 1'b0, busy = 1'b0, samp_ready = 1'b1;
    logic [11:0] bus_in;
    logic        cs_n, rd_n, hben, samp_valid, samp_err;
    logic [11:0] samp_data;
    logic [1:0]  samp_chan;

    int checks = 0;
    int errors = 0;

    adc_par_reader #(.RD_LOW_CYC(RDL), .ACCESS_CYC(ACC), .TURN_CYC(TRN)) uut (
        .clk(clk), .rst(rst), .word_mode(word_mode), .ten_bit(ten_bit), .busy(busy),
        .bus_in(bus_in), .cs_n(cs_n), .rd_n(rd_n), .hben(hben), .samp_ready(samp_ready),
        .samp_valid(samp_valid), .samp_data(samp_data), .samp_chan(samp_chan), .samp_err(samp_err)
    );

    // converter bus model: garbage until the access delay has elapsed
    logic [11:0] m_word = '0;
    logic [7:0]  m_lo = '0, m_hi = '0;
    logic [3:0]  m_junk = '0;
    int          lowcnt = 0;

    always @(posedge clk) lowcnt <= (!cs_n && !rd_n) ? lowcnt + 1 : 0;

    always_comb begin
        if (!cs_n && !rd_n && lowcnt >= ACC)
            bus_in = word_mode ? m_word : {m_junk, (hben ? m_hi : m_lo)};
        else
            bus_in = 12'h5A5;
    end

    // strobe monitor
    logic prev_rd = 1'b1;
    int   falls = 0, lo_run = 0, last_low = 0, gap_run = 0, last_gap = 0, busy_viol = 0;
    logic hb_log [0:3];
    initial for (int i = 0; i < 4; i++) hb_log[i] = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!rd_n && prev_rd) begin
                hb_log[falls % 4] = hben;
                falls = falls + 1;
                if (busy) busy_viol = busy_viol + 1;
                if (gap_run > 0) last_gap = gap_run;
            end
            if (!rd_n) lo_run = lo_run + 1;
            else begin
                if (!prev_rd) last_low = lo_run;
                lo_run = 0;
            end
            if (!cs_n && rd_n) gap_run = gap_run + 1;
            else gap_run = 0;
        end
        prev_rd = rd_n;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_busy();
        @(negedge clk) busy = 1'b1;
        repeat (3) @(negedge clk);
        busy = 1'b0;
    endtask

    task automatic set_model(input logic wm, input logic tb, input logic [11:0] v,
                             input logic [1:0] ch, input logic [1:0] eb);
        if (tb) begin
            m_word = {v[9:0], v[1:0] ^ 2'b10};
            m_lo   = {v[5:0], ~v[1:0]};
            m_hi   = {eb, ch, v[9:6]};
        end else begin
            m_word = v;
            m_lo   = v[7:0];
            m_hi   = {eb, ch, v[11:8]};
        end
        m_junk    = v[3:0] ^ 4'h9;
        word_mode = wm;
        ten_bit   = tb;
    endtask

    task automatic wait_valid(output logic seen);
        seen = 1'b0;
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            if (samp_valid) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic do_conv(input logic wm, input logic tb, input logic [11:0] v,
                           input logic [1:0] ch, input logic [1:0] eb);
        logic [11:0] exp_d;
        logic [1:0]  exp_c;
        logic        exp_e, seen;
        int          f0;
        exp_d = tb ? {2'b00, v[9:0]} : v;
        exp_c = wm ? 2'b00 : ch;
        exp_e = wm ? 1'b0 : |eb;
        @(negedge clk);
        set_model(wm, tb, v, ch, eb);
        f0 = falls;
        pulse_busy();
        wait_valid(seen);
        check(seen, "R2 sample after busy fall", int'(seen), 1);
        // R4 R5 R7 R8 data assembly
        check(samp_data == exp_d, wm ? (tb ? "R5 word10 data" : "R4 word12 data")
                                     : (tb ? "R8 byte10 data" : "R7 byte12 data"),
              samp_data, exp_d);
        check(samp_chan == exp_c, wm ? "R4 word chan" : "R7 byte chan", samp_chan, exp_c);
        check(samp_err == exp_e, "R9 err flag", samp_err, exp_e);
        repeat (2) @(posedge clk);
        check(falls - f0 == (wm ? 1 : 2), "R6 strobe count", falls - f0, wm ? 1 : 2);
        check(hb_log[f0 % 4] == 1'b0, "R6 first strobe hben", hb_log[f0 % 4], 0);
        if (!wm) begin
            check(hb_log[(f0 + 1) % 4] == 1'b1, "R6 second strobe hben", hb_log[(f0 + 1) % 4], 1);
            check(last_gap >= TRN, "R10 gap between strobes", last_gap, TRN);
        end
        check(last_low == LOWC, "R3 strobe width", last_low, LOWC);
        check(busy_viol == 0, "R2 strobe during busy", busy_viol, 0);
        repeat (TRN + 2) @(negedge clk);
        check(cs_n && rd_n, "R10 strobes released", {cs_n, rd_n}, 3);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R11 watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic seen;
        logic [11:0] held;
        repeat (3) @(negedge clk);
        check(cs_n && rd_n && !hben && !samp_valid, "R1 reset outputs",
              {cs_n, rd_n, hben, samp_valid}, 4'b1100);
        rst = 1'b0;
        @(negedge clk);
        check(cs_n && rd_n && !samp_valid, "R1 after reset", {cs_n, rd_n, samp_valid}, 3'b110);
        busy = 1'b1;
        repeat (6) @(negedge clk);
        check(cs_n && rd_n, "R2 no read while busy high", {cs_n, rd_n}, 3);
        busy = 1'b0;
        wait_valid(seen);
        repeat (TRN + 4) @(negedge clk);

        // R4 sweep
        for (int v = 0; v < 4096; v += 3) do_conv(1'b1, 1'b0, 12'(v), 2'b00, 2'b00);
        // R5 sweep
        for (int v = 0; v < 1024; v++) do_conv(1'b1, 1'b1, 12'(v), 2'b00, 2'b00);
        // R7 sweep
        for (int v = 0; v < 4096; v += 5) do_conv(1'b0, 1'b0, 12'(v), 2'(v >> 2), 2'b00);
        // R8 sweep
        for (int v = 0; v < 1024; v++) do_conv(1'b0, 1'b1, 12'(v), 2'(v >> 3), 2'b00);
        // R9 reserved bits
        for (int e = 1; e < 4; e++) begin
            do_conv(1'b0, 1'b0, 12'hA5C, 2'(e), 2'(e));
            do_conv(1'b0, 1'b1, 12'h2B7, 2'(e), 2'(e));
        end

        // R11 backpressure with a busy fall that arrives during the wait
        @(negedge clk);
        samp_ready = 1'b0;
        set_model(1'b1, 1'b0, 12'h3C1, 2'b00, 2'b00);
        pulse_busy();
        wait_valid(seen);
        check(seen && samp_data == 12'h3C1, "R11 first held sample", samp_data, 12'h3C1);
        held = samp_data;
        @(negedge clk);
        set_model(1'b1, 1'b0, 12'h9E4, 2'b00, 2'b00);
        pulse_busy();
        for (int n = 0; n < 10; n++) begin
            @(negedge clk);
            check(samp_valid && samp_data == held, "R11 valid held", samp_data, held);
            check(cs_n && rd_n, "R11 no read while waiting", {cs_n, rd_n}, 3);
        end
        samp_ready = 1'b1;
        @(negedge clk);
        check(!samp_valid, "R11 valid drops on ready", samp_valid, 0);
        wait_valid(seen);
        check(seen && samp_data == 12'h9E4, "R2 remembered busy fall", samp_data, 12'h9E4);
        @(negedge clk);
        check(!samp_valid, "R11 one-cycle pulse", samp_valid, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule